// File: doc/BRIEF.md
# Multi-Channel Reload Timer Unit

This block is a set of down-counting timer channels behind a small register bus that is addressed in bytes. A parameter selects two or three channels. Each channel holds a reload constant, a live count, a control word and, on the third channel only, a general-purpose capture word. A channel counts down once every prescaled period while it runs. When it steps from zero, it reloads from its constant and raises an underflow flag. Its interrupt output follows that flag, gated by an enable bit.

A shared start register holds one run bit per channel. Clearing a bit freezes that channel with its count intact, and setting the bit again resumes counting from where it stopped. An optional output-control register keeps a single bit.

The bus is a plain strobe interface with no back-pressure. A write takes effect on the clock edge where `bus_wr` is high. Read data is registered and appears one cycle after the edge where `bus_rd` is high, and it is held until the next read. Because the block never stalls, no valid/ready handshake is needed. Unmapped or misaligned addresses read as zero, and writes to them change nothing.

Top module: `multi_timer_unit`

## Requirements
- R1: After reset, the start register reads 0. Each channel's reload and count read 0xFFFFFFFF, each control word reads 0, and all interrupt outputs are low.
- R2: Each channel window begins at a fixed byte address: 0x08 for channel 0, 0x14 for channel 1 and 0x20 for channel 2. Inside a window, the reload register is at +0, the count at +4 and the control word at +8, and channel 2 adds the capture word at +0xC.
- R3: The start register sits at 0x04, and bit i runs channel i. A read returns the bits written for the channels that exist, and all other bits read 0.
- R4: While its start bit is 0, a channel's count is held. On resume, counting continues from the held count and the held prescaler phase.
- R5: Control bits [2:0] select the prescale. A value s from 0 to 4 gives one decrement per 4^(s+1) running cycles, and the values 5 to 7 never count. A write to the control word restarts the prescale phase.
- R6: When the count is 0 at a prescaled step, the count loads the reload value and the underflow flag sets.
- R7: The underflow flag appears at control bit 8 and the interrupt enable at control bit 5. The interrupt output is high exactly when both are set. A control write with bit 8 = 0 clears the flag, and a write with bit 8 = 1 leaves it unchanged.
- R8: The control word reads back only bits [2:0], 5 and 8. Every other bit reads 0.
- R9: Address 0x00 stores bit 0 of written data when the output-control parameter is set. Otherwise it reads 0.
- R10: Only channel 2 has a capture word, and it is a plain read/write store. When the three-channel parameter is clear, the 0x20 window reads 0, start bit 2 is not stored and `irq_o[2]` stays low.
- R11: Unmapped or misaligned addresses read 0, and writes to them change no register. Read data is valid one cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW (8) | Byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Registered read data, valid the cycle after `bus_rd` |
| irq_o | output | 3 | Per-channel interrupt; bit 2 is tied low without the third channel |

## Verification
The bench builds two copies that share one bus. One has three channels and the output-control bit. The other has two channels and no output-control bit. This lets a single write show the capture word, start bit 2 and the 0x00 register being stored in one copy and ignored in the other. Both copies run at the fastest prescale for most tests, which keeps underflow and pause/resume within a few dozen cycles. Prescale value 4 is also run for 2048 cycles to cover the longest divider.

// File: rtl/tu_pkg.sv
package tu_pkg;
  typedef enum logic [1:0] {
    REG_RELOAD = 2'd0,
    REG_COUNT  = 2'd1,
    REG_CTRL   = 2'd2,
    REG_CAPT   = 2'd3
  } reg_idx_e;

  localparam int OCTL_ADDR  = 'h00;
  localparam int START_ADDR = 'h04;

  localparam int CTL_IE   = 5;
  localparam int CTL_FLAG = 8;

  function automatic int chan_base(input int ch);
    case (ch)
      0:       return 'h08;
      1:       return 'h14;
      default: return 'h20;
    endcase
  endfunction
endpackage

// File: rtl/tu_prescale.sv
module tu_prescale #(
  parameter int PSW = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       clr,
  input  logic [2:0] sel,
  output logic       tick
);
  logic [PSW-1:0] pre_q;
  logic [PSW-1:0] mask;
  logic           sel_ok;

  always_comb begin
    sel_ok = (sel <= 3'd4);
    mask   = '0;
    for (int k = 0; k < PSW; k++)
      if (k < 2 * int'(sel) + 2) mask[k] = 1'b1;
  end

  assign tick = run && sel_ok && ((pre_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pre_q <= '0;
    else if (clr) pre_q <= '0;
    else if (run) pre_q <= pre_q + 1'b1;
  end

  AST_NO_TICK_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (sel > 3'd4) |-> !tick); // R5
endmodule

// File: rtl/tu_chan.sv
module tu_chan
  import tu_pkg::*;
#(
  parameter int DW       = 32,
  parameter bit HAS_CAPT = 1'b0,
  parameter int PSW      = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          wr,
  input  reg_idx_e      idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  logic [DW-1:0] reload_q, cnt_q, capt_q;
  logic [2:0]    sel_q;
  logic          ie_q, flag_q, tick;
  logic          wr_reload, wr_cnt, wr_ctl, wr_capt;

  assign wr_reload = wr && (idx == REG_RELOAD);
  assign wr_cnt    = wr && (idx == REG_COUNT);
  assign wr_ctl    = wr && (idx == REG_CTRL);
  assign wr_capt   = wr && (idx == REG_CAPT) && HAS_CAPT;

  tu_prescale #(.PSW(PSW)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .clr(wr_ctl), .sel(sel_q), .tick(tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '1;
      cnt_q    <= '1;
      sel_q    <= '0;
      ie_q     <= 1'b0;
      flag_q   <= 1'b0;
      capt_q   <= '0;
    end else begin
      if (wr_reload) reload_q <= wdata;
      if (wr_capt)   capt_q   <= wdata;
      if (wr_ctl) begin
        sel_q <= wdata[2:0];
        ie_q  <= wdata[CTL_IE];
      end
      if (wr_cnt)          cnt_q <= wdata;
      else if (tick)       cnt_q <= (cnt_q == '0) ? reload_q : cnt_q - 1'b1;
      if (tick && !wr_cnt && cnt_q == '0)  flag_q <= 1'b1;
      else if (wr_ctl && !wdata[CTL_FLAG]) flag_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (idx)
      REG_RELOAD: rdata = reload_q;
      REG_COUNT:  rdata = cnt_q;
      REG_CTRL: begin
        rdata[2:0]      = sel_q;
        rdata[CTL_IE]   = ie_q;
        rdata[CTL_FLAG] = flag_q;
      end
      default:    rdata = HAS_CAPT ? capt_q : '0;
    endcase
  end

  assign irq = flag_q && ie_q;

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_cnt) |=> $stable(cnt_q)); // R4
  AST_COUNT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_cnt && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R5
  AST_UNDERFLOW_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_cnt && cnt_q == '0) |=> (cnt_q == $past(reload_q) && flag_q)); // R6
endmodule

// File: rtl/multi_timer_unit.sv
module multi_timer_unit
  import tu_pkg::*;
#(
  parameter int DW        = 32,
  parameter int AW        = 8,
  parameter int PSW       = 10,
  parameter bit THREE_CH  = 1'b1,
  parameter bit OUTCTL_EN = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [2:0]    irq_o
);
  localparam int NCH = THREE_CH ? 3 : 2;

  logic [NCH-1:0] start_q;
  logic           oc_q;
  logic [NCH-1:0] ch_hit;
  logic [NCH-1:0] ch_irq;
  reg_idx_e       ch_idx [NCH];
  logic [DW-1:0]  ch_rd  [NCH];
  logic           hit_oc, hit_start, addr_ok;
  logic [DW-1:0]  rd_mux;

  assign hit_oc    = (bus_addr == AW'(OCTL_ADDR)) && OUTCTL_EN;
  assign hit_start = (bus_addr == AW'(START_ADDR));

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam int BASE = chan_base(g);
    localparam int NREG = (g == 2) ? 4 : 3;
    logic [AW-1:0] off;
    assign off       = bus_addr - AW'(BASE);
    assign ch_hit[g] = (bus_addr >= AW'(BASE)) && (off < AW'(NREG * 4)) &&
                       (bus_addr[1:0] == 2'b00);
    assign ch_idx[g] = reg_idx_e'(off[3:2]);

    tu_chan #(.DW(DW), .HAS_CAPT(g == 2), .PSW(PSW)) u_ch (
      .clk(clk), .rst_n(rst_n), .run(start_q[g]), .wr(bus_wr && ch_hit[g]),
      .idx(ch_idx[g]), .wdata(bus_wdata), .rdata(ch_rd[g]), .irq(ch_irq[g])
    );
  end

  assign addr_ok = hit_oc || hit_start || (|ch_hit);

  always_comb begin
    rd_mux = '0;
    if (hit_oc)    rd_mux[0] = oc_q;
    if (hit_start) rd_mux[NCH-1:0] = start_q;
    for (int i = 0; i < NCH; i++)
      if (ch_hit[i]) rd_mux = ch_rd[i];
  end

  always_comb begin
    irq_o = '0;
    for (int i = 0; i < NCH; i++) irq_o[i] = ch_irq[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q   <= '0;
      oc_q      <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (bus_wr && hit_start) start_q <= bus_wdata[NCH-1:0];
      if (bus_wr && hit_oc)    oc_q    <= bus_wdata[0];
      if (bus_rd)              bus_rdata <= rd_mux;
    end
  end

  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(START_ADDR)) |=> (start_q == $past(bus_wdata[NCH-1:0]))); // R3
  AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !addr_ok) |=> (bus_rdata == '0)); // R11
endmodule

// File: tb/multi_timer_unit_test.sv
module multi_timer_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata_a, rdata_b;
  logic [2:0]  irq_a, irq_b;
  logic [31:0] ra, rb;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  multi_timer_unit uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_a), .irq_o(irq_a)
  );

  multi_timer_unit #(.THREE_CH(1'b0), .OUTCTL_EN(1'b0)) uut_two (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .irq_o(irq_b)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    ra = rdata_a; rb = rdata_b;
  endtask

  task automatic run_for(input logic [31:0] mask, input int cycles);
    wr(8'h04, mask);
    repeat (cycles - 1) @(negedge clk);
    wr(8'h04, 32'h0);
  endtask

  task automatic t_reset;
    chk(irq_a == 3'b000, "R1 irq", {29'd0, irq_a}, 32'h0);
    rd(8'h04); chk(ra == 32'h0, "R1 start", ra, 32'h0);
    rd(8'h08); chk(ra == 32'hFFFF_FFFF, "R1 reload", ra, 32'hFFFF_FFFF);
    rd(8'h0C); chk(ra == 32'hFFFF_FFFF, "R1 count", ra, 32'hFFFF_FFFF);
    rd(8'h10); chk(ra == 32'h0, "R1 ctrl", ra, 32'h0);
  endtask

  task automatic t_start_reg;
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04);
    chk(ra == 32'h7, "R3 start readback", ra, 32'h7);
    chk(rb == 32'h3, "R10 start bit2 dropped", rb, 32'h3);
    wr(8'h04, 32'h0);
    rd(8'h04); chk(ra == 32'h0, "R3 start cleared", ra, 32'h0);
  endtask

  task automatic t_window;
    wr(8'h14, 32'hAAAA_0001);
    wr(8'h18, 32'h55);
    wr(8'h1C, 32'h3);
    rd(8'h14); chk(ra == 32'hAAAA_0001, "R2 ch1 reload", ra, 32'hAAAA_0001);
    rd(8'h18); chk(ra == 32'h55, "R2 ch1 count", ra, 32'h55);
    rd(8'h1C); chk(ra == 32'h3, "R2 ch1 ctrl", ra, 32'h3);
    rd(8'h08); chk(ra == 32'hFFFF_FFFF, "R2 ch0 untouched", ra, 32'hFFFF_FFFF);
  endtask

  task automatic t_pause;
    wr(8'h10, 32'h0);
    wr(8'h0C, 32'd100);
    run_for(32'h1, 10);
    repeat (20) @(negedge clk);
    rd(8'h0C); chk(ra == 32'd98, "R4 paused count", ra, 32'd98);
    run_for(32'h1, 6);
    rd(8'h0C); chk(ra == 32'd96, "R4 resumed count", ra, 32'd96);
  endtask

  task automatic t_prescale;
    wr(8'h10, 32'h1);
    wr(8'h0C, 32'd1000);
    run_for(32'h1, 40);
    rd(8'h0C); chk(ra == 32'd998, "R5 div16", ra, 32'd998);
    wr(8'h10, 32'h4);
    wr(8'h0C, 32'd1000);
    run_for(32'h1, 2048);
    rd(8'h0C); chk(ra == 32'd998, "R5 div1024", ra, 32'd998);
    wr(8'h10, 32'h6);
    wr(8'h0C, 32'd1000);
    run_for(32'h1, 100);
    rd(8'h0C); chk(ra == 32'd1000, "R5 reserved no count", ra, 32'd1000);
  endtask

  task automatic t_underflow;
    wr(8'h1C, 32'h020);
    wr(8'h14, 32'd5);
    wr(8'h18, 32'd1);
    run_for(32'h2, 8);
    rd(8'h18); chk(ra == 32'd5, "R6 reload on underflow", ra, 32'd5);
    chk(irq_a[1] == 1'b1, "R7 irq raised", {31'd0, irq_a[1]}, 32'h1);
    rd(8'h1C); chk(ra == 32'h120, "R6 flag set", ra, 32'h120);
    wr(8'h1C, 32'hFFFF_FFF8);
    rd(8'h1C); chk(ra == 32'h120, "R8 ctrl mask", ra, 32'h120);
    chk(irq_a[1] == 1'b1, "R7 flag kept", {31'd0, irq_a[1]}, 32'h1);
    wr(8'h1C, 32'h100);
    chk(irq_a[1] == 1'b0, "R7 enable off", {31'd0, irq_a[1]}, 32'h0);
    rd(8'h1C); chk(ra == 32'h100, "R7 flag without enable", ra, 32'h100);
    wr(8'h1C, 32'h020);
    chk(irq_a[1] == 1'b0, "R7 flag cleared irq", {31'd0, irq_a[1]}, 32'h0);
    rd(8'h1C); chk(ra == 32'h020, "R7 flag cleared", ra, 32'h020);
  endtask

  task automatic t_outctl;
    wr(8'h00, 32'hFF);
    rd(8'h00);
    chk(ra == 32'h1, "R9 outctl stored", ra, 32'h1);
    chk(rb == 32'h0, "R9 outctl absent", rb, 32'h0);
  endtask

  task automatic t_capture;
    wr(8'h2C, 32'h1234_5678);
    rd(8'h2C);
    chk(ra == 32'h1234_5678, "R10 capture rw", ra, 32'h1234_5678);
    chk(rb == 32'h0, "R10 capture absent", rb, 32'h0);
    wr(8'h20, 32'h77);
    rd(8'h20); chk(rb == 32'h0, "R10 ch2 window absent", rb, 32'h0);
    chk(irq_b[2] == 1'b0, "R10 irq2 low", {31'd0, irq_b[2]}, 32'h0);
  endtask

  task automatic t_bad;
    wr(8'h30, 32'hDEAD);
    rd(8'h30); chk(ra == 32'h0, "R11 unmapped read", ra, 32'h0);
    rd(8'h0B); chk(ra == 32'h0, "R11 misaligned read", ra, 32'h0);
    wr(8'h0A, 32'h1234);
    rd(8'h08); chk(ra == 32'hFFFF_FFFF, "R11 misaligned write ignored", ra, 32'hFFFF_FFFF);
    rd(8'h04); chk(ra == 32'h0, "R11 one-cycle read", ra, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_start_reg;
    t_window;
    t_pause;
    t_prescale;
    t_underflow;
    t_outctl;
    t_capture;
    t_bad;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'h1, 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule